// File: doc/BRIEF.md
# Priority I/O Crossbar Pin Assigner

This block decides which of sixteen general-purpose port pins carries which digital peripheral signal. The pins form two 8-bit ports. Pin index 0 to 7 is port 0 bit 0 to 7, and pin index 8 to 15 is port 1 bit 0 to 7. Software-style enable inputs name the peripherals that want pins. A 16-bit skip mask removes pins from the search, so they stay free for analog use, for special functions or for plain GPIO. A mode bit selects SPI 3-wire or 4-wire operation.

Signals are placed greedily in a fixed priority order. Each requested signal takes the lowest pin that is neither skipped nor already taken. The top-priority UART is the exception: it always lands on two fixed pins in port 0. The assignment is worked out combinationally and then registered. Pad logic uses the registered outputs to steer its multiplexers. These are a per-pin function code and, for each signal, a pin index with a valid flag.

The block has no internal sequencing and only one operating state. Its outputs follow the inputs one clock later, and reset returns every pin to GPIO.

Top module: `pin_xbar`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released with all enables low, every pin code is 0 and every signal valid flag is 0.
- R2: With `uart_en` high, UART TX (signal 0) is on pin 4 and UART RX (signal 1) is on pin 5. This holds whatever skip bits 4 and 5 say, and the two pins are reserved before any other signal is placed. With `uart_en` low, pins 4 and 5 are open to other signals.
- R3: The signal indices and the order in which signals are placed are: 0 UART TX, 1 UART RX, 2 SPI clock, 3 SPI master-in, 4 SPI master-out, 5 SPI slave-select, 6 LIN TX, 7 LIN RX, 8 comparator 0 output, 9 comparator 0 async output, 10 system clock output, 11 to 13 capture/compare outputs 0 to 2, 14 counter external clock input, 15 timer 0 input, 16 timer 1 input. Each requested signal from index 2 upward takes the lowest pin that is not skipped and not taken by a lower-index signal.
- R4: A pin whose bit is set in `skip_mask` (bit k = pin k) is never given to signals 2 to 16.
- R5: Signal 5 (SPI slave-select) is requested only when `spi_en` and `spi_four_wire` are both high. Signals 2 to 4 are requested whenever `spi_en` is high.
- R6: `capcmp_count` = n (0 to 3) requests capture/compare outputs 0 to n-1 and no others.
- R7: A requested signal that finds no free pin has its valid flag low and its pin field 0. Every signal not placed reads valid 0 and pin 0.
- R8: Each pin has a 5-bit code. Code 0 means GPIO. Code c from 1 to 17 means that signal index c-1 owns the pin. Pin p's code is in `pin_code[5p+4:5p]`, and signal s's pin index is in `sig_pin[4s+3:4s]`.
- R9: The outputs change only on the clock edge that follows a change of any enable, mode or skip input, and they reflect that change there.
- R10: No pin is owned by two signals. The number of nonzero pin codes equals the number of set valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | Request UART TX and RX |
| spi_en | input | 1 | Request SPI clock, master-in, master-out |
| spi_four_wire | input | 1 | Also request SPI slave-select |
| lin_en | input | 1 | Request LIN TX and RX |
| cmp0_en | input | 1 | Request comparator 0 output |
| cmp0a_en | input | 1 | Request comparator 0 async output |
| sysclk_out_en | input | 1 | Request system clock output |
| capcmp_count | input | 2 | Number of capture/compare outputs requested |
| cnt_clk_in_en | input | 1 | Request counter external clock input |
| tmr0_in_en | input | 1 | Request timer 0 input |
| tmr1_in_en | input | 1 | Request timer 1 input |
| skip_mask | input | 16 | Bit k set removes pin k from the search |
| pin_code | output | 80 | Registered 5-bit function code per pin |
| sig_pin | output | 68 | Registered 4-bit pin index per signal |
| sig_valid | output | 17 | Registered placement flag per signal |

## Verification
Two functions can act on the same pins in the same cycle: the fixed UART reservation and the lowest-free search for everything else. Both compete for pins 4 and 5. The bench provokes this by toggling `uart_en` while the skip bits of those two pins and of nearby pins change. It checks that the UART wins and ignores its skip bits, and that the search flows around the reserved pins. A second overlap comes from exhaustion while a mode change removes or adds the slave-select pin. This happens when a dense skip mask meets SPI 3-wire/4-wire switching. A queue-based placement model in the bench judges the result on every clock.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Number of placeable signals and width of the per-pin function code
    localparam int NUM_SIG = 17;
    localparam int CODE_W  = 5;
    localparam int CEX_MAX = 3;
    localparam int CNT_W   = 2;

    // Signal indices in placement priority order
    localparam int SIG_UART_TX = 0;
    localparam int SIG_UART_RX = 1;
    localparam int SIG_SPI_SCK = 2;
    localparam int SIG_SPI_MI  = 3;
    localparam int SIG_SPI_MO  = 4;
    localparam int SIG_SPI_SEL = 5;
    localparam int SIG_LIN_TX  = 6;
    localparam int SIG_LIN_RX  = 7;
    localparam int SIG_CMP0    = 8;
    localparam int SIG_CMP0A   = 9;
    localparam int SIG_SYSCLK  = 10;
    localparam int SIG_CEX0    = 11;
    localparam int SIG_CNTCLK  = 14;
    localparam int SIG_TMR0    = 15;
    localparam int SIG_TMR1    = 16;

    // First signal that goes through the lowest-free search
    localparam int SIG_FIRST_SEARCH = 2;

endpackage

// File: rtl/xbar_request.sv
module xbar_request
    import xbar_pkg::*;
(
    input  logic             uart_en,
    input  logic             spi_en,
    input  logic             spi_four_wire,
    input  logic             lin_en,
    input  logic             cmp0_en,
    input  logic             cmp0a_en,
    input  logic             sysclk_out_en,
    input  logic [CNT_W-1:0] capcmp_count,
    input  logic             cnt_clk_in_en,
    input  logic             tmr0_in_en,
    input  logic             tmr1_in_en,
    output logic [NUM_SIG-1:0] req
);

    assign req[SIG_UART_TX] = uart_en;
    assign req[SIG_UART_RX] = uart_en;
    assign req[SIG_SPI_SCK] = spi_en;
    assign req[SIG_SPI_MI]  = spi_en;
    assign req[SIG_SPI_MO]  = spi_en;
    assign req[SIG_SPI_SEL] = spi_en & spi_four_wire;   // R5
    assign req[SIG_LIN_TX]  = lin_en;
    assign req[SIG_LIN_RX]  = lin_en;
    assign req[SIG_CMP0]    = cmp0_en;
    assign req[SIG_CMP0A]   = cmp0a_en;
    assign req[SIG_SYSCLK]  = sysclk_out_en;
    assign req[SIG_CNTCLK]  = cnt_clk_in_en;
    assign req[SIG_TMR0]    = tmr0_in_en;
    assign req[SIG_TMR1]    = tmr1_in_en;

    // R6: a count of n requests the first n capture/compare outputs
    for (genvar k = 0; k < CEX_MAX; k++) begin : g_cex
        assign req[SIG_CEX0 + k] = (capcmp_count > CNT_W'(k));
    end

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
    import xbar_pkg::*;
#(
    parameter int NUM_PINS    = 16,
    parameter int UART_TX_PIN = 4,
    localparam int PIN_W      = $clog2(NUM_PINS)
) (
    input  logic [NUM_SIG-1:0]  req,
    input  logic [NUM_PINS-1:0] skip,
    output logic [PIN_W-1:0]    pin_idx [NUM_SIG],
    output logic [NUM_SIG-1:0]  valid
);

    logic [NUM_PINS-1:0] taken;
    logic                found;
    logic [PIN_W-1:0]    pick;

    always_comb begin
        taken = '0;
        valid = '0;
        found = 1'b0;
        pick  = '0;
        for (int s = 0; s < NUM_SIG; s++) begin
            pin_idx[s] = '0;
        end

        // R2: fixed UART pins are reserved first, skip bits not consulted
        if (req[SIG_UART_TX]) begin
            taken[UART_TX_PIN]      = 1'b1;
            pin_idx[SIG_UART_TX]    = PIN_W'(UART_TX_PIN);
            valid[SIG_UART_TX]      = 1'b1;
        end
        if (req[SIG_UART_RX]) begin
            taken[UART_TX_PIN + 1]  = 1'b1;
            pin_idx[SIG_UART_RX]    = PIN_W'(UART_TX_PIN + 1);
            valid[SIG_UART_RX]      = 1'b1;
        end

        // R3/R4/R7: greedy lowest-free search in priority order
        for (int s = SIG_FIRST_SEARCH; s < NUM_SIG; s++) begin
            found = 1'b0;
            pick  = '0;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (!found && !skip[p] && !taken[p]) begin
                    found = 1'b1;
                    pick  = PIN_W'(p);
                end
            end
            if (req[s] && found) begin
                taken[pick] = 1'b1;
                pin_idx[s]  = pick;
                valid[s]    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xbar_pinmap.sv
module xbar_pinmap
    import xbar_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic [PIN_W-1:0]   pin_idx [NUM_SIG],
    input  logic [NUM_SIG-1:0] valid,
    output logic [CODE_W-1:0]  code [NUM_PINS]
);

    // R8: pin code is owner index plus one, zero for GPIO
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            code[p] = '0;
            for (int s = 0; s < NUM_SIG; s++) begin
                if (valid[s] && (pin_idx[s] == PIN_W'(p))) begin
                    code[p] = CODE_W'(s + 1);
                end
            end
        end
    end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
    import xbar_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int NUM_PORTS   = 2,
    parameter int UART_TX_PIN = 4,
    localparam int NUM_PINS   = PORT_W * NUM_PORTS,
    localparam int PIN_W      = $clog2(NUM_PINS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        uart_en,
    input  logic                        spi_en,
    input  logic                        spi_four_wire,
    input  logic                        lin_en,
    input  logic                        cmp0_en,
    input  logic                        cmp0a_en,
    input  logic                        sysclk_out_en,
    input  logic [CNT_W-1:0]            capcmp_count,
    input  logic                        cnt_clk_in_en,
    input  logic                        tmr0_in_en,
    input  logic                        tmr1_in_en,
    input  logic [NUM_PINS-1:0]         skip_mask,
    output logic [NUM_PINS*CODE_W-1:0]  pin_code,
    output logic [NUM_SIG*PIN_W-1:0]    sig_pin,
    output logic [NUM_SIG-1:0]          sig_valid
);

    logic [NUM_SIG-1:0] req;
    logic [PIN_W-1:0]   idx_d   [NUM_SIG];
    logic [NUM_SIG-1:0] valid_d;
    logic [CODE_W-1:0]  code_d  [NUM_PINS];

    logic [PIN_W-1:0]   idx_q   [NUM_SIG];
    logic [NUM_SIG-1:0] valid_q;
    logic [CODE_W-1:0]  code_q  [NUM_PINS];

    xbar_request u_req (
        .uart_en       (uart_en),
        .spi_en        (spi_en),
        .spi_four_wire (spi_four_wire),
        .lin_en        (lin_en),
        .cmp0_en       (cmp0_en),
        .cmp0a_en      (cmp0a_en),
        .sysclk_out_en (sysclk_out_en),
        .capcmp_count  (capcmp_count),
        .cnt_clk_in_en (cnt_clk_in_en),
        .tmr0_in_en    (tmr0_in_en),
        .tmr1_in_en    (tmr1_in_en),
        .req           (req)
    );

    xbar_alloc #(
        .NUM_PINS    (NUM_PINS),
        .UART_TX_PIN (UART_TX_PIN)
    ) u_alloc (
        .req     (req),
        .skip    (skip_mask),
        .pin_idx (idx_d),
        .valid   (valid_d)
    );

    xbar_pinmap #(
        .NUM_PINS (NUM_PINS)
    ) u_map (
        .pin_idx (idx_d),
        .valid   (valid_d),
        .code    (code_d)
    );

    // R1/R9: one register stage, reset to all-GPIO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int s = 0; s < NUM_SIG; s++)  idx_q[s]  <= '0;
            for (int p = 0; p < NUM_PINS; p++) code_q[p] <= '0;
        end else begin
            valid_q <= valid_d;
            for (int s = 0; s < NUM_SIG; s++)  idx_q[s]  <= idx_d[s];
            for (int p = 0; p < NUM_PINS; p++) code_q[p] <= code_d[p];
        end
    end

    logic [NUM_PINS-1:0] pin_used;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_out
        assign pin_code[p*CODE_W +: CODE_W] = code_q[p];
        assign pin_used[p] = (code_q[p] != '0);
    end

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig_out
        assign sig_pin[s*PIN_W +: PIN_W] = idx_q[s];
    end
    assign sig_valid = valid_q;

    // ---------------- assertions ----------------

    // R2: UART always sits on its fixed pins
    a_r2_uart_tx_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[SIG_UART_TX] |-> (idx_q[SIG_UART_TX] == PIN_W'(UART_TX_PIN)));
    a_r2_uart_rx_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[SIG_UART_RX] |-> (idx_q[SIG_UART_RX] == PIN_W'(UART_TX_PIN + 1)));

    // R5: slave-select only placed after a 4-wire SPI request
    a_r5_sel_needs_4wire: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[SIG_SPI_SEL] |-> $past(spi_en && spi_four_wire));

    // R10: number of owned pins matches number of placed signals
    a_r10_count_match: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_used) == $countones(valid_q));

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig_chk
        // R8: the pin named by a placed signal carries that signal's code
        a_r8_code_back: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[s] |-> (code_q[idx_q[s]] == CODE_W'(s + 1)));
        // R7: unplaced signals read pin 0
        a_r7_unplaced_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_q[s] |-> (idx_q[s] == '0));
        if (s >= SIG_FIRST_SEARCH) begin : g_search
            // R4: searched signals never land on a pin skipped last cycle
            a_r4_skip_honoured: assert property (@(posedge clk) disable iff (!rst_n)
                valid_q[s] |-> ((($past(skip_mask) >> idx_q[s]) & NUM_PINS'(1)) == '0));
        end
    end

endmodule

// File: tb/test_pin_xbar.sv
module test_pin_xbar;

    localparam int NP = 16;
    localparam int NS = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uart_en = 0, spi_en = 0, spi_four_wire = 0, lin_en = 0;
    logic        cmp0_en = 0, cmp0a_en = 0, sysclk_out_en = 0;
    logic [1:0]  capcmp_count = 0;
    logic        cnt_clk_in_en = 0, tmr0_in_en = 0, tmr1_in_en = 0;
    logic [15:0] skip_mask = 0;
    logic [79:0] pin_code;
    logic [67:0] sig_pin;
    logic [16:0] sig_valid;

    int n_checks = 0;
    int n_fail   = 0;

    int exp_code [NP];
    int exp_pin  [NS];
    int exp_val  [NS];

    always #5 clk = ~clk;

    pin_xbar i_pin_xbar (
        .clk, .rst_n, .uart_en, .spi_en, .spi_four_wire, .lin_en,
        .cmp0_en, .cmp0a_en, .sysclk_out_en, .capcmp_count,
        .cnt_clk_in_en, .tmr0_in_en, .tmr1_in_en, .skip_mask,
        .pin_code, .sig_pin, .sig_valid
    );

    function automatic int get_pin(int s);
        return int'(sig_pin[s*4 +: 4]);
    endfunction
    function automatic int get_code(int p);
        return int'(pin_code[p*5 +: 5]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Behavioural placement model: free pins held in an ascending queue
    task automatic model();
        bit rq [NS];
        int freeq [$];
        rq[0] = uart_en;  rq[1] = uart_en;
        rq[2] = spi_en;   rq[3] = spi_en;  rq[4] = spi_en;
        rq[5] = spi_en && spi_four_wire;
        rq[6] = lin_en;   rq[7] = lin_en;
        rq[8] = cmp0_en;  rq[9] = cmp0a_en; rq[10] = sysclk_out_en;
        rq[11] = capcmp_count > 0; rq[12] = capcmp_count > 1; rq[13] = capcmp_count > 2;
        rq[14] = cnt_clk_in_en; rq[15] = tmr0_in_en; rq[16] = tmr1_in_en;
        foreach (exp_code[p]) exp_code[p] = 0;
        foreach (exp_pin[s]) begin exp_pin[s] = 0; exp_val[s] = 0; end
        for (int p = 0; p < NP; p++) begin
            if (skip_mask[p]) continue;
            if (uart_en && (p == 4 || p == 5)) continue;
            freeq.push_back(p);
        end
        if (uart_en) begin
            exp_pin[0] = 4; exp_val[0] = 1; exp_code[4] = 1;
            exp_pin[1] = 5; exp_val[1] = 1; exp_code[5] = 2;
        end
        for (int s = 2; s < NS; s++) begin
            if (rq[s] && freeq.size() > 0) begin
                int p = freeq.pop_front();
                exp_pin[s] = p; exp_val[s] = 1; exp_code[p] = s + 1;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        int vb = 0, pb = 0, cb = 0;
        int used = 0;
        for (int s = 0; s < NS; s++) begin
            if (int'(sig_valid[s]) != exp_val[s]) vb++;
            if (get_pin(s) != exp_pin[s]) pb++;
        end
        for (int p = 0; p < NP; p++) begin
            if (get_code(p) != exp_code[p]) cb++;
            if (get_code(p) != 0) used++;
        end
        chk(vb == 0, {tag, " R3 valid flags"}, int'(sig_valid), 0);
        chk(pb == 0, {tag, " R3 R7 signal pins"}, pb, 0);
        chk(cb == 0, {tag, " R8 pin codes"}, cb, 0);
        chk(used == $countones(sig_valid), {tag, " R10 owner count"}, used, $countones(sig_valid));
    endtask

    // Inputs have just been changed: outputs must hold until the next edge
    task automatic tick(input string tag);
        #1;
        compare_all({tag, " R9 hold before edge"});
        model();
        @(posedge clk);
        #2;
        compare_all(tag);
    endtask

    task automatic clear_in();
        uart_en = 0; spi_en = 0; spi_four_wire = 0; lin_en = 0;
        cmp0_en = 0; cmp0a_en = 0; sysclk_out_en = 0; capcmp_count = 0;
        cnt_clk_in_en = 0; tmr0_in_en = 0; tmr1_in_en = 0; skip_mask = 0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        foreach (exp_code[p]) exp_code[p] = 0;
        foreach (exp_pin[s]) begin exp_pin[s] = 0; exp_val[s] = 0; end
        uart_en = 1; spi_en = 1;
        repeat (3) @(posedge clk);
        #2;
        chk(sig_valid == '0, "R1 valid low in reset", int'(sig_valid), 0);
        chk(pin_code == '0, "R1 codes zero in reset", int'(pin_code != 0), 0);
        clear_in();
        rst_n = 1'b1;
        tick("R1 first cycle after reset");

        // R2: UART on pins 4/5 even with those pins skipped
        uart_en = 1; skip_mask = 16'h0030;
        tick("R2 uart skipped pins");
        chk(get_pin(0) == 4 && sig_valid[0], "R2 tx pin", get_pin(0), 4);
        chk(get_pin(1) == 5 && sig_valid[1], "R2 rx pin", get_pin(1), 5);

        // R3 + R5: SPI 4-wire then LIN around UART
        skip_mask = 0; spi_en = 1; spi_four_wire = 1; lin_en = 1;
        tick("R3 spi lin uart");
        chk(get_pin(5) == 3, "R3 R5 slave-select pin", get_pin(5), 3);
        chk(get_pin(6) == 6, "R3 lin tx skips uart pins", get_pin(6), 6);
        chk(get_pin(7) == 7, "R3 lin rx", get_pin(7), 7);

        // R5: 3-wire drops slave-select, LIN moves down
        spi_four_wire = 0;
        tick("R5 three wire");
        chk(sig_valid[5] == 1'b0, "R5 no slave-select", int'(sig_valid[5]), 0);
        chk(get_pin(6) == 3, "R5 lin tx moves up", get_pin(6), 3);

        // R2: uart off frees pins 4/5
        uart_en = 0; spi_four_wire = 1;
        tick("R2 uart off");
        chk(get_pin(6) == 4, "R2 lin tx on freed pin 4", get_pin(6), 4);

        // R4: skipped pins passed over
        clear_in(); tmr0_in_en = 1; tmr1_in_en = 1; skip_mask = 16'h00FF;
        tick("R4 skip port0");
        chk(get_pin(15) == 8, "R4 timer0 on pin 8", get_pin(15), 8);
        chk(get_pin(16) == 9, "R4 timer1 on pin 9", get_pin(16), 9);

        // R6: capture/compare count
        clear_in(); capcmp_count = 2;
        tick("R6 count two");
        chk(sig_valid[13:11] == 3'b011, "R6 cex0 cex1 only", int'(sig_valid[13:11]), 3);
        capcmp_count = 0;
        tick("R6 count zero");
        chk(sig_valid[13:11] == 3'b000, "R6 none", int'(sig_valid[13:11]), 0);

        // R7: exhaustion
        clear_in(); skip_mask = 16'hFFFE; spi_en = 1; tmr1_in_en = 1;
        tick("R7 one pin left");
        chk(sig_valid[2] && get_pin(2) == 0, "R7 sck gets pin 0", get_pin(2), 0);
        chk(!sig_valid[3] && get_pin(3) == 0, "R7 miso unplaced", int'(sig_valid[3]), 0);
        chk(!sig_valid[16], "R7 timer1 unplaced", int'(sig_valid[16]), 0);

        // Random mix, including uart toggling against skipped pins 4/5
        for (int i = 0; i < 400; i++) begin
            uart_en = 1'($urandom); spi_en = 1'($urandom); spi_four_wire = 1'($urandom);
            lin_en = 1'($urandom); cmp0_en = 1'($urandom); cmp0a_en = 1'($urandom);
            sysclk_out_en = 1'($urandom); capcmp_count = 2'($urandom);
            cnt_clk_in_en = 1'($urandom); tmr0_in_en = 1'($urandom); tmr1_in_en = 1'($urandom);
            case (i % 4)
                0: skip_mask = 16'($urandom);
                1: skip_mask = 16'($urandom) | 16'hFF30;
                2: skip_mask = 16'($urandom) & 16'h00F0;
                default: skip_mask = 16'h0;
            endcase
            tick("R3 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule